// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block sits between a processor core and an external memory and peripheral bus whose low address byte and data byte share one set of eight pins. It accepts one memory-access request at a time from the core. It turns each request into a bus cycle of exactly five clocks. In that cycle an address strobe latches the low address byte, a data strobe frames the transfer, and the upper address bits stay on dedicated lines for the whole cycle. Read data comes back to the core with a one-clock completion pulse.

When no request is waiting, the sequencer runs dummy read cycles, so both strobes keep a fixed rate of one pulse every five clocks. Two low-power inputs silence the strobes and release the bus. They take effect only at a cycle boundary. An instruction-fetch marker accompanies opcode reads so debug equipment can tell them apart from data reads.

The request side is valid/ready. The core raises `req_valid` with its fields and must hold all of them unchanged until a clock edge where `req_ready` is also high. That edge accepts the request. `req_ready` is high for only one clock per bus cycle, so back-pressure lasts up to four clocks in normal running and for as long as a low-power input is active. The response side cannot be stalled: `rsp_valid` is a single-clock pulse, and the core must take `rsp_rdata` in that clock.

Top module: `mux_bus_seq`

## Requirements
- R1: `bus_addr_hi` carries address bits 12..8 of the current cycle throughout the cycle. In clock 0 of an active cycle, `bus_out` carries address bits 7..0 with `bus_oe` high.
- R2: In an active cycle, `bus_as` is high in clock 0 only, so it pulses once every five clocks.
- R3: In an active cycle, `bus_ds` is high in clocks 2 and 3 only, and it is never high together with `bus_as`.
- R4: `bus_rw_n` is low for the whole of a write cycle and high for read and dummy cycles. It does not change while `bus_ds` is high.
- R5: For a write, `bus_out` carries the write data with `bus_oe` high in clocks 1 to 3. For a read, `bus_oe` is low in clocks 1 to 4. `bus_oe` is low in clock 4 of every cycle.
- R6: For a read, `bus_in` is captured at the clock edge that ends clock 3. It is shown on `rsp_rdata` in clock 4, together with a one-clock `rsp_valid`. Writes also get the `rsp_valid` pulse in clock 4.
- R7: `req_ready` is high only in clock 4 and only while both low-power inputs are low. A request accepted at the end of clock 4 runs in the cycle that starts on the next clock.
- R8: A cycle with no accepted request is a dummy read. In it, `bus_rw_n` is high, `bus_li` is low, `rsp_valid` stays low, and both strobes still run.
- R9: `bus_li` is high in clocks 1 to 3 of a read cycle whose request had `req_fetch` set. `req_fetch` has no effect on a write.
- R10: `idle_mode` and `stop_mode` are sampled only at the end of clock 4. A cycle that begins while either was high has no strobes, no bus drive, `bus_rw_n` high and `bus_li` low. Normal cycles resume at the first boundary where both inputs are low.
- R11: `rst_n` is active-low and synchronous. After an edge with it low, the phase returns to clock 0. Strobes, `bus_oe`, `bus_li` and `rsp_valid` stay low, and `bus_rw_n` stays high, until the first cycle boundary after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one bus cycle is five periods |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 13 | Full access address |
| req_wdata | input | 8 | Data for a write |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an opcode fetch |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Data captured by the latest read |
| idle_mode | input | 1 | Light low-power request |
| stop_mode | input | 1 | Deep low-power request |
| bus_addr_hi | output | 5 | Non-multiplexed address bits 12..8 |
| bus_out | output | 8 | Shared-bus value driven by the block |
| bus_oe | output | 1 | Block drives the shared bus |
| bus_in | input | 8 | Shared-bus value seen at the pins |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_rw_n | output | 1 | High = read, low = write |
| bus_li | output | 1 | Opcode-fetch marker |

## Verification
The bench builds the block with its default widths, a 13-bit address and an 8-bit bus. With these widths it can write to and read back from both ends of the address space, 0x0000 and 0x1FFF, so every upper address line is seen both all low and all high. A behavioural bus device latches the address on the address strobe and serves reads from a sparse memory. This makes a write followed by a read a true round trip. With the narrow default widths, back-to-back requests, suspension by either low-power input, a request stalled through a suspension, and a reset in mid-cycle all fit in a few hundred clocks.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  // clock positions inside one five-clock bus cycle
  typedef enum logic [2:0] {
    PH_ADDR = 3'd0,
    PH_HOLD = 3'd1,
    PH_DS1  = 3'd2,
    PH_DS2  = 3'd3,
    PH_REL  = 3'd4
  } phase_e;

  localparam int unsigned CYCLE_CLKS = 5;
endpackage

// File: rtl/mbs_phase_ctr.sv
module mbs_phase_ctr
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   last
);
  phase_e phase_q;

  assign phase = phase_q;
  assign last  = (phase_q == PH_REL);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= PH_ADDR;
    else if (last) phase_q <= PH_ADDR;
    else           phase_q <= phase_e'(phase_q + 3'd1);
  end
endmodule

// File: rtl/mbs_cycle_reg.sv
module mbs_cycle_reg #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              idle_mode,
  input  logic              stop_mode,
  output logic              cur_valid,
  output logic              cur_write,
  output logic              cur_fetch,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              susp
);
  logic lp_req;
  logic take;

  assign lp_req    = idle_mode | stop_mode;
  assign req_ready = last & ~lp_req;
  assign take      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp      <= 1'b1;
      cur_valid <= 1'b0;
      cur_write <= 1'b0;
      cur_fetch <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (last) begin
      susp      <= lp_req;
      cur_valid <= take;
      if (take) begin
        cur_write <= req_write;
        cur_fetch <= req_fetch & ~req_write;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end else begin
        cur_write <= 1'b0;
        cur_fetch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_e                   phase,
  input  logic                     susp,
  input  logic                     cur_valid,
  input  logic                     cur_write,
  input  logic                     cur_fetch,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic [DATA_W-1:0]        cur_wdata,
  input  logic [DATA_W-1:0]        bus_in,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic                     bus_as,
  output logic                     bus_ds,
  output logic                     bus_rw_n,
  output logic                     bus_li,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata
);
  logic            active;
  logic            wr_cyc;
  logic            rd_cyc;
  logic            mid_phase;
  logic            strobe_ph;
  logic [DATA_W-1:0] rdata_q;

  assign active    = ~susp;
  assign wr_cyc    = cur_valid & cur_write;
  assign rd_cyc    = cur_valid & ~cur_write;
  assign strobe_ph = (phase == PH_DS1) | (phase == PH_DS2);
  assign mid_phase = (phase == PH_HOLD) | strobe_ph;

  assign bus_addr_hi = cur_addr[ADDR_W-1:DATA_W];
  assign bus_out     = (phase == PH_ADDR) ? cur_addr[DATA_W-1:0] : cur_wdata;
  assign bus_oe      = active & ((phase == PH_ADDR) | (wr_cyc & mid_phase));
  assign bus_as      = active & (phase == PH_ADDR);
  assign bus_ds      = active & strobe_ph;
  assign bus_rw_n    = ~(active & wr_cyc);
  assign bus_li      = active & rd_cyc & cur_fetch & mid_phase;
  assign rsp_valid   = cur_valid & (phase == PH_REL);
  assign rsp_rdata   = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  rdata_q <= '0;
    else if (active && rd_cyc && phase == PH_DS2) rdata_q <= bus_in;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              idle_mode,
  input  logic              stop_mode,
  output logic [HI_W-1:0]   bus_addr_hi,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic              bus_as,
  output logic              bus_ds,
  output logic              bus_rw_n,
  output logic              bus_li
);
  phase_e            phase;
  logic              last;
  logic              susp;
  logic              cur_valid;
  logic              cur_write;
  logic              cur_fetch;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  mbs_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .last  (last)
  );

  mbs_cycle_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .last      (last),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_write (req_write),
    .req_fetch (req_fetch),
    .idle_mode (idle_mode),
    .stop_mode (stop_mode),
    .cur_valid (cur_valid),
    .cur_write (cur_write),
    .cur_fetch (cur_fetch),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .susp      (susp)
  );

  mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .susp        (susp),
    .cur_valid   (cur_valid),
    .cur_write   (cur_write),
    .cur_fetch   (cur_fetch),
    .cur_addr    (cur_addr),
    .cur_wdata   (cur_wdata),
    .bus_in      (bus_in),
    .bus_addr_hi (bus_addr_hi),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .bus_as      (bus_as),
    .bus_ds      (bus_ds),
    .bus_rw_n    (bus_rw_n),
    .bus_li      (bus_li),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic bus_oe,
  input logic bus_as,
  input logic bus_ds,
  input logic bus_rw_n,
  input logic bus_li
);
  // R2
  as_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> !bus_as);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_as && bus_ds));

  // R3
  ds_two_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds && $past(bus_ds)) |=> !bus_ds);

  // R4
  rw_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds && $past(bus_ds)) |-> $stable(bus_rw_n));

  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds && bus_rw_n) |-> !bus_oe);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  ready_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R9
  fetch_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_li |-> bus_rw_n);

  // R11
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!bus_as && !bus_ds && !bus_oe && !rsp_valid));
endmodule

bind mux_bus_seq mbs_checker u_mbs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_oe    (bus_oe),
  .bus_as    (bus_as),
  .bus_ds    (bus_ds),
  .bus_rw_n  (bus_rw_n),
  .bus_li    (bus_li)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        idle_mode = 1'b0;
  logic        stop_mode = 1'b0;
  logic [4:0]  bus_addr_hi;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  bus_in;
  logic        bus_as, bus_ds, bus_rw_n, bus_li;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (.*);

  function automatic logic [7:0] dflt(int a);
    return 8'((a * 37 + (a >> 5)) ^ 8'hA5);
  endfunction

  // bus device: latches address on AS, serves reads, stores writes
  logic [7:0] d_mem [int];
  int         dev_addr = 0;
  logic [7:0] dev_rd = 8'h00;
  assign bus_in = (bus_ds && bus_rw_n) ? dev_rd : 8'hEE;

  always @(negedge clk) begin
    if (bus_as && bus_oe) begin
      dev_addr = {bus_addr_hi, bus_out};
      dev_rd   = d_mem.exists(dev_addr) ? d_mem[dev_addr] : dflt(dev_addr);
    end
    if (bus_ds && !bus_rw_n) d_mem[dev_addr] = bus_out;
  end

  // behavioural reference
  logic [7:0] m_mem [int];
  int   m_ph = 0, m_addr = 0, m_wdata = 0, m_rdata = 0;
  bit   m_susp = 1, m_val = 0, m_wr = 0, m_fe = 0, m_post = 1, started = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_ph = 0; m_susp = 1; m_val = 0; m_wr = 0; m_fe = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0; m_post = 1;
    end else begin
      if (m_ph == 3 && !m_susp && m_val && !m_wr)
        m_rdata = m_mem.exists(m_addr) ? m_mem[m_addr] : dflt(m_addr);
      if (m_ph == 4) begin
        m_post = 0;
        m_susp = idle_mode || stop_mode;
        m_val  = req_valid && !m_susp;
        if (m_val) begin
          m_wr = req_write; m_fe = req_fetch; m_addr = req_addr; m_wdata = req_wdata;
          if (m_wr) m_mem[m_addr] = 8'(m_wdata);
        end else begin
          m_wr = 0; m_fe = 0;
        end
      end
      m_ph = (m_ph + 1) % 5;
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  function automatic string tag(string own);
    if (m_susp && m_post) return "R11";
    if (m_susp)           return "R10";
    if (!m_val)           return "R8";
    return own;
  endfunction

  always @(posedge clk) begin
    #5;
    if (started) begin
      bit act, e_wr, mid;
      act  = !m_susp;
      e_wr = m_val && m_wr;
      mid  = (m_ph >= 1 && m_ph <= 3);
      chk(tag("R2"), "bus_as", bus_as, act && m_ph == 0);
      chk(tag("R3"), "bus_ds", bus_ds, act && (m_ph == 2 || m_ph == 3));
      chk(tag("R4"), "bus_rw_n", bus_rw_n, !e_wr);
      chk(tag("R9"), "bus_li", bus_li, act && m_val && !m_wr && m_fe && mid);
      chk(tag("R5"), "bus_oe", bus_oe, act && (m_ph == 0 || (e_wr && mid)));
      if (bus_oe && m_ph == 0) chk("R1", "bus_out(addr)", bus_out, m_addr & 8'hFF);
      if (bus_oe && m_ph != 0) chk("R5", "bus_out(data)", bus_out, m_wdata);
      chk(tag("R1"), "bus_addr_hi", bus_addr_hi, (m_addr >> 8) & 5'h1F);
      chk(tag("R6"), "rsp_valid", rsp_valid, m_val && m_ph == 4);
      if (m_val && m_ph == 4 && !m_wr) chk("R6", "rsp_rdata", rsp_rdata, m_rdata);
      chk(tag("R7"), "req_ready", req_ready, m_ph == 4 && !(idle_mode || stop_mode));
    end
  end

  // request task: called just after a falling edge
  task automatic req(int a, int d, bit w, bit f);
    req_valid = 1; req_addr = 13'(a); req_wdata = 8'(d); req_write = w; req_fetch = f;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (12) @(negedge clk);             // R8 dummy cycles
    req(13'h0000, 8'h11, 1, 0);             // R1 low end
    req(13'h1FFF, 8'hEE, 1, 0);             // R1 high end
    req(13'h0A5C, 8'h3C, 1, 0);
    req(13'h0000, 0, 0, 0);                 // R6 round trips
    req(13'h1FFF, 0, 0, 0);
    req(13'h0A5C, 0, 0, 0);
    req(13'h1234, 0, 0, 0);                 // unwritten location
    req(13'h0100, 0, 0, 1);                 // R9 fetch
    req(13'h0200, 8'h77, 1, 1);             // R9 fetch flag ignored on write
    repeat (7) @(negedge clk);
    @(negedge clk); idle_mode = 1;          // R10 mid-cycle entry
    fork
      req(13'h0300, 0, 0, 1);               // stalled through suspension
      begin repeat (14) @(negedge clk); idle_mode = 0; end
    join
    repeat (3) @(negedge clk);
    stop_mode = 1;
    repeat (11) @(negedge clk);
    stop_mode = 0;
    req(13'h0200, 0, 0, 0);
    req(13'h0444, 8'h5A, 1, 0);
    repeat (2) @(negedge clk);
    rst_n = 0;                              // R11 mid-cycle reset
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    req(13'h0444, 0, 0, 0);
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule